// File: doc/BRIEF.md
# Multiprocessor Interrupt Control Register Block

This block is the interrupt-control part of a chipset register file that serves four processors. The bus is 64 bits wide but carries 32 bits per beat. A beat with address bit 2 clear holds the lower half of a value. A beat with address bit 2 set supplies the upper half and commits the whole 64-bit value to the register chosen by the address with bit 2 cleared.

The block holds three kinds of state:
- A shared control word whose fields follow different write rules: clear-on-one, set-on-one, set-once and request-to-set. From that word it drives one inter-processor interrupt line and one timer-interrupt clear strobe per processor.
- A 64-bit device-interrupt mask for each processor. Each processor's device interrupt line is asserted whenever its mask and the raw device request vector share a set bit.
- Four 24-bit interrupt configuration registers.

Offsets for timing, probe, power and performance registers are decoded and their writes are discarded. The read-only offsets also discard writes. A commit to any other offset raises a one-cycle unassigned-access strobe.

A combinational read port returns the stored registers, so software and the bench can observe them.

Top module: `mp_irq_regs`

## Requirements
- R1: A beat with wr_addr[2]=0 only captures wr_data as the pending lower half and changes no visible state. A beat with wr_addr[2]=1 commits {wr_data, pending lower half} at that clock edge, and the result is visible after the edge.
- R2: A commit to the control word at offset 0x080 clears every stored bit where the written value has a 1 within mask 0x10000FF0.
- R3: In a control-word commit with bit 20 set, bits 23:16 become zero. Otherwise, written 1s in bits 23:20 set those bits, and written bits 19:16 are copied in only if bits 19:16 are all zero at that time.
- R4: Written 1s in bits 15:12 of a control-word commit set bits 11:8. Setting is applied after clearing, so a bit that is both cleared and requested in the same commit ends up set.
- R5: A control-word commit replaces bits 43:40 with the written bits 43:40.
- R6: When a control-word commit changes any of bits 11:4, ipi_o[i] takes the new bit 8+i. Otherwise ipi_o keeps its value.
- R7: When a control-word commit changes any of bits 11:4, timer_clr_o[i] is high for the single cycle after the commit if the new bit 4+i is 0. No other event raises timer_clr_o.
- R8: Offsets 0x200, 0x240, 0x600 and 0x640 hold the masks of processors 0 to 3, and each commit updates only its own mask. dev_irq_o[i] is the OR-reduction of mask i AND dev_req, and it follows dev_req combinationally.
- R9: Offsets 0x380, 0x3C0, 0x700 and 0x740 store only bits 23:0 of the committed value. They read back zero-extended.
- R10: Commits to read-only offsets (0x280, 0x2C0, 0x300, 0x680, 0x6C0) and to the discarded offsets change no state and raise no error. The discarded offsets are 0x000, 0x040, 0x0C0, 0x100 to 0x1C0 in steps of 0x40, 0x340, 0x400 to 0x4C0 in steps of 0x40, 0x580, 0x5C0, 0x780, and 0xC00 to 0xCC0 in steps of 0x40.
- R11: A commit to any other offset leaves all state unchanged and sets acc_err_o high for exactly the cycle after the commit.
- R12: After reset, all registers, outputs and the pending lower half are zero.
- R13: rd_data returns the following, with any other address reading zero:

  | rd_addr | rd_data |
  |---|---|
  | 0x080 | control word |
  | mask offsets | that mask |
  | configuration offsets | that register |
  | 0x300 | dev_req |
  | 0x280, 0x2C0, 0x680, 0x6C0 | mask AND dev_req for processors 0 to 3 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write beat valid |
| wr_addr | input | AW | Byte address of the beat; bit 2 selects the upper half |
| wr_data | input | 32 | Beat data |
| dev_req | input | 64 | Raw device interrupt request vector |
| rd_addr | input | AW | Read address |
| rd_data | output | 64 | Read data, combinational |
| ipi_o | output | 4 | Inter-processor interrupt line per processor |
| timer_clr_o | output | 4 | One-cycle timer interrupt clear per processor |
| dev_irq_o | output | 4 | Device interrupt line per processor |
| acc_err_o | output | 1 | One-cycle unassigned-access strobe |

## Verification
Register state, ipi_o, timer_clr_o and acc_err_o all change at the clock edge that takes the upper-half beat. The bench drives every beat on a falling edge and checks these results at the next falling edge, halfway into the cycle after the commit. That is the only cycle in which the strobes are high. dev_irq_o, rd_data and the request-derived reads have no register in their path, so they are checked one time unit after the stimulus changes, inside the same cycle.

// File: rtl/mp_irq_regs.sv
module mp_irq_regs #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [63:0]   dev_req,
  input  logic [AW-1:0] rd_addr,
  output logic [63:0]   rd_data,
  output logic [3:0]    ipi_o,
  output logic [3:0]    timer_clr_o,
  output logic [3:0]    dev_irq_o,
  output logic          acc_err_o
);
  localparam int NCPU = 4;

  logic [31:0] lo_q;
  logic [63:0] misc_q, misc_nxt, misc_diff;
  logic [63:0] mask_q [NCPU];
  logic [23:0] cfg_q  [NCPU];
  logic [3:0]  ipi_q, tclr_q;
  logic        err_q;

  logic          commit;
  logic [63:0]   wv;
  logic [AW-1:0] ca;
  logic          sel_misc, unk;
  logic [3:0]    sel_mask, sel_cfg;

  assign commit = wr_en & wr_addr[2];
  assign wv     = {wr_data, lo_q};
  assign ca     = {wr_addr[AW-1:3], 1'b0, wr_addr[1:0]};

  always_comb begin
    sel_misc = 1'b0;
    sel_mask = '0;
    sel_cfg  = '0;
    unk      = 1'b0;
    case (ca)
      AW'(12'h080): sel_misc = 1'b1;
      AW'(12'h200): sel_mask = 4'b0001;
      AW'(12'h240): sel_mask = 4'b0010;
      AW'(12'h600): sel_mask = 4'b0100;
      AW'(12'h640): sel_mask = 4'b1000;
      AW'(12'h380): sel_cfg  = 4'b0001;
      AW'(12'h3C0): sel_cfg  = 4'b0010;
      AW'(12'h700): sel_cfg  = 4'b0100;
      AW'(12'h740): sel_cfg  = 4'b1000;
      AW'(12'h000), AW'(12'h040), AW'(12'h0C0),
      AW'(12'h100), AW'(12'h140), AW'(12'h180), AW'(12'h1C0),
      AW'(12'h280), AW'(12'h2C0), AW'(12'h300), AW'(12'h340),
      AW'(12'h400), AW'(12'h440), AW'(12'h480), AW'(12'h4C0),
      AW'(12'h580), AW'(12'h5C0), AW'(12'h680), AW'(12'h6C0),
      AW'(12'h780), AW'(12'hC00), AW'(12'hC40), AW'(12'hC80),
      AW'(12'hCC0): ;
      default: unk = 1'b1;
    endcase
  end

  always_comb begin
    misc_nxt = misc_q & ~(wv & 64'h0000_0000_1000_0FF0);
    if (wv[20]) begin
      misc_nxt[23:16] = 8'h00;
    end else begin
      misc_nxt[23:20] = misc_nxt[23:20] | wv[23:20];
      if (misc_nxt[19:16] == 4'h0) misc_nxt[19:16] = wv[19:16];
    end
    misc_nxt[11:8]  = misc_nxt[11:8] | wv[15:12];
    misc_nxt[43:40] = wv[43:40];
  end

  assign misc_diff = misc_nxt ^ misc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      misc_q <= '0;
      ipi_q  <= '0;
      tclr_q <= '0;
      err_q  <= 1'b0;
      for (int i = 0; i < NCPU; i++) begin
        mask_q[i] <= '0;
        cfg_q[i]  <= '0;
      end
    end else begin
      tclr_q <= '0;
      err_q  <= 1'b0;
      if (wr_en && !wr_addr[2]) lo_q <= wr_data;
      if (commit) begin
        err_q <= unk;
        if (sel_misc) begin
          misc_q <= misc_nxt;
          if (|misc_diff[11:4]) begin
            ipi_q  <= misc_nxt[11:8];
            tclr_q <= ~misc_nxt[7:4];
          end
        end
        for (int i = 0; i < NCPU; i++) begin
          if (sel_mask[i]) mask_q[i] <= wv;
          if (sel_cfg[i])  cfg_q[i]  <= wv[23:0];
        end
      end
    end
  end

  for (genvar g = 0; g < NCPU; g++) begin : g_dev
    assign dev_irq_o[g] = |(mask_q[g] & dev_req);
  end

  assign ipi_o       = ipi_q;
  assign timer_clr_o = tclr_q;
  assign acc_err_o   = err_q;

  always_comb begin
    case (rd_addr)
      AW'(12'h080): rd_data = misc_q;
      AW'(12'h200): rd_data = mask_q[0];
      AW'(12'h240): rd_data = mask_q[1];
      AW'(12'h600): rd_data = mask_q[2];
      AW'(12'h640): rd_data = mask_q[3];
      AW'(12'h380): rd_data = {40'h0, cfg_q[0]};
      AW'(12'h3C0): rd_data = {40'h0, cfg_q[1]};
      AW'(12'h700): rd_data = {40'h0, cfg_q[2]};
      AW'(12'h740): rd_data = {40'h0, cfg_q[3]};
      AW'(12'h300): rd_data = dev_req;
      AW'(12'h280): rd_data = mask_q[0] & dev_req;
      AW'(12'h2C0): rd_data = mask_q[1] & dev_req;
      AW'(12'h680): rd_data = mask_q[2] & dev_req;
      AW'(12'h6C0): rd_data = mask_q[3] & dev_req;
      default:      rd_data = '0;
    endcase
  end
endmodule

// File: rtl/mp_irq_regs_chk.sv
module mp_irq_regs_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [63:0]   misc_q,
  input logic [63:0]   dev_req,
  input logic [3:0]    ipi_o,
  input logic [3:0]    timer_clr_o,
  input logic [3:0]    dev_irq_o,
  input logic          acc_err_o
);
  AST_LOW_HALF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[2]) |=> $stable(misc_q)); // R1
  AST_SET_ONCE_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (misc_q[19:16] != 4'h0) |=> (misc_q[19:16] == $past(misc_q[19:16]) || misc_q[19:16] == 4'h0)); // R3
  AST_IPI_MATCHES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_o == misc_q[11:8]); // R6
  AST_TCLR_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|timer_clr_o) |-> $past(wr_en && wr_addr[2])); // R7
  AST_IDLE_REQ_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req == 64'h0) |-> (dev_irq_o == 4'h0)); // R8
  AST_ERR_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err_o |-> $past(wr_en && wr_addr[2])); // R11
endmodule

bind mp_irq_regs mp_irq_regs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .misc_q(misc_q), .dev_req(dev_req), .ipi_o(ipi_o),
  .timer_clr_o(timer_clr_o), .dev_irq_o(dev_irq_o), .acc_err_o(acc_err_o)
);

// File: tb/mp_irq_regs_bench.sv
module mp_irq_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] dev_req = '0;
  logic [11:0] rd_addr = '0;
  logic [63:0] rd_data;
  logic [3:0]  ipi_o, timer_clr_o, dev_irq_o;
  logic        acc_err_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  mp_irq_regs #(.AW(12)) u_mp_irq_regs (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr64(input logic [11:0] a, input logic [63:0] d);
    beat(a, d[31:0]);
    beat(a | 12'h4, d[63:32]);
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    rd(12'h080, v); chk("R12 word", v, 0);
    rd(12'h200, v); chk("R12 mask0", v, 0);
    chk("R12 outs", {ipi_o, timer_clr_o, dev_irq_o, 3'b0, acc_err_o}, 0);
  endtask

  task automatic t_halves();
    logic [63:0] v;
    beat(12'h080, 32'h0000_1000);
    repeat (3) @(negedge clk);
    rd(12'h080, v); chk("R1 low only", v, 0);
    chk("R1 ipi idle", ipi_o, 0);
    beat(12'h084, 32'h0);
    rd(12'h080, v); chk("R1 commit", v, 64'h100);
    chk("R6 ipi", ipi_o, 4'h1);
    chk("R7 tclr", timer_clr_o, 4'hF);
    @(negedge clk); chk("R7 one cycle", timer_clr_o, 4'h0);
  endtask

  task automatic t_ipi();
    logic [63:0] v;
    wr64(12'h080, 64'hF000);
    rd(12'h080, v); chk("R4 set", v, 64'hF00);
    chk("R6 ipi F", ipi_o, 4'hF);
    chk("R7 tclr on change", timer_clr_o, 4'hF);
    wr64(12'h080, 64'h100);
    rd(12'h080, v); chk("R2 w1c", v, 64'hE00);
    chk("R6 ipi E", ipi_o, 4'hE);
    wr64(12'h080, 64'h2200);
    rd(12'h080, v); chk("R4 set wins", v, 64'hE00);
    chk("R7 no change no tclr", timer_clr_o, 4'h0);
  endtask

  task automatic t_fields();
    logic [63:0] v;
    wr64(12'h080, 64'h00A5_0000);
    rd(12'h080, v); chk("R3 set", v, 64'h00A5_0E00);
    chk("R7 quiet", timer_clr_o, 4'h0);
    wr64(12'h080, 64'h0003_0000);
    rd(12'h080, v); chk("R3 set once", v, 64'h00A5_0E00);
    wr64(12'h080, 64'h0040_0000);
    rd(12'h080, v); chk("R3 w1s high", v, 64'h00E5_0E00);
    wr64(12'h080, 64'h0010_0000);
    rd(12'h080, v); chk("R3 bulk clear", v, 64'hE00);
    wr64(12'h080, 64'h0000_0A00_0000_0000);
    rd(12'h080, v); chk("R5 load", v, 64'h0000_0A00_0000_0E00);
    wr64(12'h080, 64'h0000_0500_1000_0000);
    rd(12'h080, v); chk("R5 replace", v, 64'h0000_0500_0000_0E00);
    wr64(12'h080, 64'h0000_0500_0000_0E00);
    rd(12'h080, v); chk("R2 clear ipi", v, 64'h0000_0500_0000_0000);
    chk("R6 ipi 0", ipi_o, 4'h0);
    chk("R7 tclr", timer_clr_o, 4'hF);
  endtask

  task automatic t_masks();
    logic [63:0] v;
    wr64(12'h600, 64'h10);
    chk("R8 no req", dev_irq_o, 4'h0);
    dev_req = 64'h10; #1;
    chk("R8 comb", dev_irq_o, 4'b0100);
    wr64(12'h240, 64'h8000_0000_0000_0000);
    dev_req = 64'h8000_0000_0000_0010; #1;
    chk("R8 two cpus", dev_irq_o, 4'b0110);
    rd(12'h200, v); chk("R8 own mask only", v, 0);
    rd(12'h240, v); chk("R13 mask1", v, 64'h8000_0000_0000_0000);
    rd(12'h680, v); chk("R13 status2", v, 64'h10);
    rd(12'h300, v); chk("R13 raw", v, 64'h8000_0000_0000_0010);
    wr64(12'h3C0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'h3C0, v); chk("R9 cfg1", v, 64'hFF_FFFF);
    wr64(12'h740, 64'h1_2345_6789);
    rd(12'h740, v); chk("R9 cfg3", v, 64'h45_6789);
  endtask

  task automatic t_ignored();
    logic [63:0] v;
    wr64(12'h300, '1);
    chk("R10 ro err", acc_err_o, 0);
    wr64(12'h040, '1);
    wr64(12'h780, '1);
    chk("R10 err", acc_err_o, 0);
    rd(12'h080, v); chk("R10 word", v, 64'h0000_0500_0000_0000);
    rd(12'h600, v); chk("R10 mask2", v, 64'h10);
    chk("R10 irq", dev_irq_o, 4'b0110);
    wr64(12'h800, '1);
    chk("R11 err", acc_err_o, 1);
    rd(12'h080, v); chk("R11 word", v, 64'h0000_0500_0000_0000);
    @(negedge clk); chk("R11 pulse", acc_err_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_halves();
    t_ipi();
    t_fields();
    t_masks();
    t_ignored();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule